// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is a 16-bit up-counting timer that produces a repeating rectangular pulse on one output. Two compare registers control it. The cycle register ends each cycle and sends the counter back to zero. The duty register marks the count after which the output drops to its inactive level. Both registers use a value-plus-one encoding. A cycle value M gives a period of M + 1 count clocks. A duty value N keeps the output high for N + 1 of those counts.

Counting advances only on system clocks where the count-clock enable is high. A 2-bit mode field starts and stops the timer. The value 11 runs the counter, and any other value stops it and clears it to zero. Each compare register has its own interrupt strobe. A strobe is one system clock wide and is raised for each match. Software writes the mode field and both compare registers through a small write port, selected by a 2-bit address. A separate enable input gates the pulse onto the output pin.

Top module: `ppg_timer`

## Requirements
- R1: While running, the counter advances by one on each count clock and returns to 0 on the count clock that follows the one where it equals the cycle value M. The period is therefore M + 1 count clocks.
- R2: The pulse is high (active level 1) while the running counter lies in 0..N, where N is the duty value. This gives N + 1 active counts per cycle. When N >= M the pulse stays high continuously.
- R3: After each count clock on which the counter equals M, cyc_irq_o is high for exactly the one following system clock.
- R4: After each count clock on which the counter equals N, duty_irq_o is high for exactly the one following system clock. When N > M it never fires.
- R5: Writes use wr_sel to pick a target: 0 is the mode field (wr_data[1:0]), 1 is the cycle value, 2 is the duty value, and 3 is ignored. Writing mode 11 from a stopped state starts counting at 0. Writing 11 while already running leaves the count undisturbed.
- R6: Writing any mode value other than 11 stops the timer and clears the counter to 0. While stopped, the pulse and both strobes are low. This includes a match that falls on the same edge as the stop write.
- R7: The counter holds its value on system clocks where cnt_en is low.
- R8: When out_en is low, pulse_o is low. The counting and both strobes are unaffected.
- R9: Compare writes made while running apply from the next clock edge. A match test on that edge still uses the old value.
- R10: After reset the mode is stopped, both compare values are 0, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count-clock enable, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 cycle, 2 duty, 3 none |
| wr_data | input | W | Write data (mode uses bits 1:0) |
| out_en | input | 1 | Gates the pulse onto pulse_o |
| pulse_o | output | 1 | Pulse output, active high |
| cyc_irq_o | output | 1 | Cycle-match interrupt strobe |
| duty_irq_o | output | 1 | Duty-match interrupt strobe |

## Verification
The assertions watch on every cycle that a stopped timer holds a zero count and keeps the pulse and both strobes quiet. They also check that a match on the cycle value sends the count to zero, that an idle count-clock enable freezes the counter, and that each strobe is caused by a matching count clock. The actual period and duty shapes can only be shown by the bench's scenarios. The same holds for the value-plus-one encodings, the behaviour when a compare value changes mid-run, and a stop that coincides with a match. The bench sweeps small cycle and duty values and compares the waveform against arithmetic on the count index.

// File: rtl/ppg_pkg.sv
`timescale 1ns/1ps
package ppg_pkg;
  typedef enum logic [1:0] {
    MODE_HALT  = 2'b00,
    MODE_RSV_A = 2'b01,
    MODE_RSV_B = 2'b10,
    MODE_RUN   = 2'b11
  } ppg_mode_e;

  typedef enum logic [1:0] {
    SEL_MODE  = 2'd0,
    SEL_CYCLE = 2'd1,
    SEL_DUTY  = 2'd2,
    SEL_NONE  = 2'd3
  } ppg_sel_e;
endpackage

// File: rtl/ppg_regs.sv
`timescale 1ns/1ps
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         run_q,
  output logic         run_d,
  output logic [W-1:0] cyc_q,
  output logic [W-1:0] cyc_d,
  output logic [W-1:0] duty_q,
  output logic [W-1:0] duty_d
);
  ppg_mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    cyc_d  = cyc_q;
    duty_d = duty_q;
    if (wr_en) begin
      case (ppg_sel_e'(wr_sel))
        SEL_MODE:  mode_d = ppg_mode_e'(wr_data[1:0]);
        SEL_CYCLE: cyc_d  = wr_data;
        SEL_DUTY:  duty_d = wr_data;
        default:   ;
      endcase
    end
  end

  assign run_q = (mode_q == MODE_RUN);
  assign run_d = (mode_d == MODE_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_HALT;
      cyc_q  <= '0;
      duty_q <= '0;
    end else begin
      mode_q <= mode_d;
      cyc_q  <= cyc_d;
      duty_q <= duty_d;
    end
  end
endmodule

// File: rtl/ppg_counter.sv
`timescale 1ns/1ps
module ppg_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         run_q,
  input  logic         run_d,
  input  logic [W-1:0] cyc_q,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d,
  output logic         tick,
  output logic         cyc_hit
);
  function automatic logic [W-1:0] advance(input logic [W-1:0] c,
                                           input logic [W-1:0] m);
    return (c == m) ? '0 : c + W'(1);
  endfunction

  assign tick    = run_q & cnt_en;
  assign cyc_hit = tick & (cnt_q == cyc_q);

  always_comb begin
    if (!run_d)    cnt_d = '0;
    else if (tick) cnt_d = advance(cnt_q, cyc_q);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ppg_outgen.sv
`timescale 1ns/1ps
module ppg_outgen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         out_en,
  input  logic         run_d,
  input  logic         tick,
  input  logic         cyc_hit,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] cnt_d,
  input  logic [W-1:0] duty_q,
  input  logic [W-1:0] duty_d,
  output logic         pulse_o,
  output logic         cyc_irq_o,
  output logic         duty_irq_o
);
  function automatic logic in_active(input logic [W-1:0] c,
                                     input logic [W-1:0] n);
    return c <= n;
  endfunction

  logic lvl_q, lvl_d;
  logic cyc_irq_q, duty_irq_q;
  logic duty_hit;

  assign duty_hit = tick & (cnt_q == duty_q);
  assign lvl_d    = run_d & in_active(cnt_d, duty_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q      <= 1'b0;
      cyc_irq_q  <= 1'b0;
      duty_irq_q <= 1'b0;
    end else begin
      lvl_q      <= lvl_d;
      cyc_irq_q  <= cyc_hit & run_d;
      duty_irq_q <= duty_hit & run_d;
    end
  end

  assign pulse_o    = lvl_q & out_en;
  assign cyc_irq_o  = cyc_irq_q;
  assign duty_irq_o = duty_irq_q;
endmodule

// File: rtl/ppg_timer.sv
`timescale 1ns/1ps
module ppg_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         out_en,
  output logic         pulse_o,
  output logic         cyc_irq_o,
  output logic         duty_irq_o
);
  logic         run_q, run_d;
  logic [W-1:0] cyc_q, cyc_d, duty_q, duty_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         tick, cyc_hit;

  ppg_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .run_q(run_q), .run_d(run_d),
    .cyc_q(cyc_q), .cyc_d(cyc_d), .duty_q(duty_q), .duty_d(duty_d)
  );

  ppg_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .run_q(run_q),
    .run_d(run_d), .cyc_q(cyc_q), .cnt_q(cnt_q), .cnt_d(cnt_d),
    .tick(tick), .cyc_hit(cyc_hit)
  );

  ppg_outgen #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .out_en(out_en), .run_d(run_d),
    .tick(tick), .cyc_hit(cyc_hit), .cnt_q(cnt_q), .cnt_d(cnt_d),
    .duty_q(duty_q), .duty_d(duty_d), .pulse_o(pulse_o),
    .cyc_irq_o(cyc_irq_o), .duty_irq_o(duty_irq_o)
  );
endmodule

// File: rtl/ppg_timer_chk.sv
`timescale 1ns/1ps
module ppg_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         wr_en,
  input logic [1:0]   wr_sel,
  input logic         pulse_o,
  input logic         cyc_irq_o,
  input logic         duty_irq_o,
  input logic         run_q,
  input logic         tick,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] cyc_q,
  input logic [W-1:0] duty_q
);
  // R6
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (!pulse_o && !cyc_irq_o && !duty_irq_o));

  // R6
  stopped_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0));

  // R1
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == cyc_q) |=> (cnt_q == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !cnt_en && !(wr_en && wr_sel == 2'd0)) |=> $stable(cnt_q));

  // R3
  cyc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_irq_o |-> $past(tick && cnt_q == cyc_q));

  // R4
  duty_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    duty_irq_o |-> $past(tick && cnt_q == duty_q));
endmodule

bind ppg_timer ppg_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
  .wr_sel(wr_sel), .pulse_o(pulse_o), .cyc_irq_o(cyc_irq_o),
  .duty_irq_o(duty_irq_o), .run_q(run_q), .tick(tick),
  .cnt_q(cnt_q), .cyc_q(cyc_q), .duty_q(duty_q)
);

// File: tb/test_ppg_timer.sv
`timescale 1ns/1ps
module test_ppg_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        out_en = 1'b1;
  logic        pulse_o, cyc_irq_o, duty_irq_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // reference state, derived from the requirements
  bit m_run = 1'b0;
  int m_cnt = 0, m_M = 0, m_N = 0;
  bit e_lvl = 1'b0, e_cyc = 1'b0, e_duty = 1'b0;

  always #10 clk = ~clk;

  ppg_timer #(.W(16)) i_ppg_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .out_en(out_en),
    .pulse_o(pulse_o), .cyc_irq_o(cyc_irq_o), .duty_irq_o(duty_irq_o)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one system clock: drive, update reference at the edge, compare at negedge
  task automatic step(input logic w, input logic [1:0] s,
                      input logic [15:0] d, input logic en, input string sc);
    bit nrun, tk;
    int nM, nN, ncnt;
    wr_en = w; wr_sel = s; wr_data = d; cnt_en = en;
    @(posedge clk);
    nrun = (w && s == 2'd0) ? (d[1:0] == 2'b11) : m_run;
    nM   = (w && s == 2'd1) ? int'(d) : m_M;
    nN   = (w && s == 2'd2) ? int'(d) : m_N;
    tk   = m_run && en;
    e_cyc  = tk && (m_cnt == m_M) && nrun;
    e_duty = tk && (m_cnt == m_N) && nrun;
    if (!nrun)   ncnt = 0;
    else if (tk) ncnt = (m_cnt == m_M) ? 0 : (m_cnt + 1) % 65536;
    else         ncnt = m_cnt;
    e_lvl = nrun && (ncnt <= nN);
    m_run = nrun; m_M = nM; m_N = nN; m_cnt = ncnt;
    @(negedge clk);
    wr_en = 1'b0;
    chk({sc, " R2 pulse"}, pulse_o, e_lvl && out_en);
    chk({sc, " R3 cyc_irq"}, cyc_irq_o, e_cyc);
    chk({sc, " R4 duty_irq"}, duty_irq_o, e_duty);
  endtask

  task automatic idle(input int n, input logic en, input string sc);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 16'd0, en, sc);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    chk("R10 pulse", pulse_o, 1'b0);
    chk("R10 cyc_irq", cyc_irq_o, 1'b0);
    chk("R10 duty_irq", duty_irq_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: compares reset to 0, so a start gives a one-count period, always high
    step(1'b1, 2'd0, 16'h0003, 1'b1, "R10 start");
    idle(4, 1'b1, "R10 run");
    chk("R10 pulse constant", pulse_o, 1'b1);
    chk("R10 cyc every count", cyc_irq_o, 1'b1);
    step(1'b1, 2'd0, 16'h0000, 1'b1, "R6 stop");

    // R1 R2 R3 R4 R5: sweep cycle and duty values, arithmetic expectations
    for (int M = 0; M <= 4; M++) begin
      for (int N = 0; N <= 5; N++) begin
        step(1'b1, 2'd1, 16'(M), 1'b0, "R5 cyc wr");
        step(1'b1, 2'd2, 16'(N), 1'b0, "R5 duty wr");
        step(1'b1, 2'd0, 16'h0003, 1'b1, "R5 start");
        chk("R2 first count", pulse_o, 1'b1);
        for (int k = 1; k <= 2 * (M + 1) + 1; k++) begin
          step(1'b0, 2'd0, 16'd0, 1'b1, "R1 sweep");
          chk("R2 sweep", pulse_o, (k % (M + 1)) <= N);
          chk("R3 sweep", cyc_irq_o, ((k - 1) % (M + 1)) == M);
          chk("R4 sweep", duty_irq_o, (N <= M) && (((k - 1) % (M + 1)) == N));
        end
        step(1'b1, 2'd0, 16'h0000, 1'b1, "R6 sweep stop");
      end
    end

    // R7: gated count clock
    step(1'b1, 2'd1, 16'd3, 1'b0, "R7 cfg");
    step(1'b1, 2'd2, 16'd1, 1'b0, "R7 cfg");
    step(1'b1, 2'd0, 16'h0003, 1'b0, "R7 start");
    for (int i = 0; i < 24; i++) step(1'b0, 2'd0, 16'd0, (i % 3) == 1, "R7 gated");

    // R8: output enable low masks the pin, strobes continue
    out_en = 1'b0;
    for (int i = 0; i < 10; i++) begin
      step(1'b0, 2'd0, 16'd0, 1'b1, "R8 masked");
      chk("R8 pin low", pulse_o, 1'b0);
    end
    out_en = 1'b1;
    idle(3, 1'b1, "R8 unmasked");

    // R5: target 3 ignored, re-writing run does not restart
    step(1'b1, 2'd3, 16'h0000, 1'b1, "R5 sel3");
    idle(2, 1'b1, "R5 sel3 after");
    step(1'b1, 2'd0, 16'h0003, 1'b1, "R5 rerun");
    idle(5, 1'b1, "R5 rerun after");

    // R9: compare changes while running
    step(1'b1, 2'd0, 16'h0000, 1'b1, "R9 stop");
    step(1'b1, 2'd1, 16'd5, 1'b0, "R9 cfg");
    step(1'b1, 2'd2, 16'd2, 1'b0, "R9 cfg");
    step(1'b1, 2'd0, 16'h0003, 1'b1, "R9 start");
    idle(2, 1'b1, "R9 run");
    step(1'b1, 2'd1, 16'd3, 1'b1, "R9 shrink cyc");
    step(1'b1, 2'd2, 16'd0, 1'b1, "R9 shrink duty");
    idle(9, 1'b1, "R9 new shape");
    step(1'b1, 2'd2, 16'd7, 1'b1, "R9 duty over cyc");
    idle(9, 1'b1, "R9 always high");
    chk("R9 constant high", pulse_o, 1'b1);

    // R6: stop on the same edge as a cycle match, and a reserved mode
    step(1'b1, 2'd2, 16'd1, 1'b1, "R6 cfg");
    while (m_cnt != m_M) step(1'b0, 2'd0, 16'd0, 1'b1, "R6 seek");
    step(1'b1, 2'd0, 16'h0000, 1'b1, "R6 stop at match");
    chk("R6 no strobe", cyc_irq_o, 1'b0);
    idle(4, 1'b1, "R6 halted");
    step(1'b1, 2'd0, 16'h0003, 1'b1, "R6 restart");
    idle(2, 1'b1, "R6 run");
    step(1'b1, 2'd0, 16'h0001, 1'b1, "R6 mode01");
    idle(4, 1'b1, "R6 mode01 halted");
    chk("R6 pin low", pulse_o, 1'b0);
    step(1'b1, 2'd0, 16'h0003, 1'b1, "R6 from zero");
    chk("R6 count zero", pulse_o, 1'b1);
    idle(6, 1'b1, "R6 resumed");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule